// File: doc/BRIEF.md
# ALU Status Flag Register

This block holds the condition flags of an 8-bit microcontroller ALU, along with two power-management flags. On each instruction that produces a result, the core presents the operand values, the operation class and a valid strobe. The block then runs its own carry chain and updates the carry, half-carry, zero and overflow flags. Each operation class updates a different subset of these flags.

Software can also write the register directly, the same way it writes any other destination. Such a write reaches only the four arithmetic flags. The power-down and time-out flags change only on their hardware events: power-up, halt, watchdog clear and watchdog time-out. When a set event and a clear event arrive in the same cycle, the clear wins.

The register is visible at all times on an 8-bit output. The two top bits of that output are always zero.

Top module: `alu_flag_reg`

## Requirements
- R1: After reset all eight status bits are 0, and bits 7 and 6 of `status_o` read 0 at all times, even after a software write of 0xFF.
- R2: For an add (`op_kind`=0), bit 0 (carry) becomes the carry out of bit 7 of `opnd_a`+`opnd_b`, and bit 1 (half-carry) becomes the carry out of bit 3.
- R3: For a subtract (`op_kind`=1, computing `opnd_a`-`opnd_b`), bit 0 becomes 1 exactly when no borrow occurs (`opnd_a` >= `opnd_b` unsigned), and bit 1 becomes 1 exactly when the low nibble of `opnd_a` is >= the low nibble of `opnd_b`.
- R4: Bit 2 (zero) becomes 1 when the 8-bit result is zero and 0 otherwise. For add and subtract the result is the computed sum or difference. For a logic operation (`op_kind`=2) the result is `res_in`.
- R5: For add and subtract, bit 3 (overflow) becomes 1 exactly when the carry into bit 7 differs from the carry out of bit 7.
- R6: A logic operation leaves bits 0, 1 and 3 unchanged.
- R7: A rotate-through-carry (`op_kind`=3) changes only bit 0. A left rotate (`rot_dir`=0) loads `opnd_a[7]` into it, and a right rotate (`rot_dir`=1) loads `opnd_a[0]`.
- R8: Bit 4 (power-down) is cleared by `ev_pwrup` or `ev_wdt_clr` and set by `ev_halt`. A clear event wins over a simultaneous halt.
- R9: Bit 5 (time-out) is cleared by `ev_pwrup`, `ev_wdt_clr` or `ev_halt` and set by `ev_wdt_to`. A clear event wins over a simultaneous time-out.
- R10: `sw_wr` loads `sw_data[3:0]` into bits 3:0. `sw_data[7:4]` is ignored. If `sw_wr` and `op_valid` arrive in the same cycle, the software value wins.
- R11: With neither `op_valid` nor `sw_wr` asserted, bits 3:0 hold their value.
- R12: Every update appears on `status_o` on the clock edge that samples the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An ALU operation completes this cycle |
| op_kind | input | 2 | 0 add, 1 subtract, 2 logic, 3 rotate through carry |
| rot_dir | input | 1 | Rotate direction: 0 left, 1 right |
| opnd_a | input | 8 | First operand (minuend, or the value being rotated) |
| opnd_b | input | 8 | Second operand (addend or subtrahend) |
| res_in | input | 8 | Result of a logic operation |
| sw_wr | input | 1 | Software write strobe |
| sw_data | input | 8 | Software write data |
| ev_pwrup | input | 1 | Power-up event |
| ev_halt | input | 1 | Halt instruction executed |
| ev_wdt_clr | input | 1 | Watchdog-clear instruction executed |
| ev_wdt_to | input | 1 | Watchdog time-out |
| status_o | output | 8 | Status register contents |

## Verification
Every flag is a register bit wired straight to `status_o`. A wrong carry-chain tap or a wrong update mask therefore shows up on the port one edge after the offending operation.

A wrong hold decision is harder to see. It stays invisible until a later logic, rotate or idle cycle, when a flag that should have held its value changes. For this reason the stimulus places logic and rotate operations directly after operations that leave distinctive flag patterns.

Errors in power-flag priority show only when set and clear events coincide. The bench drives those collisions on purpose.

// File: rtl/aluflag_pkg.sv
package aluflag_pkg;

    typedef enum logic [1:0] {
        OPK_ADD   = 2'd0,
        OPK_SUB   = 2'd1,
        OPK_LOGIC = 2'd2,
        OPK_ROT   = 2'd3
    } opk_e;

    // bit 0 is the last member
    typedef struct packed {
        logic [1:0] pad;
        logic       tmo;
        logic       pdn;
        logic       ovf;
        logic       zro;
        logic       hcy;
        logic       cy;
    } status_t;

    typedef struct packed {
        logic ovf;
        logic zro;
        logic hcy;
        logic cy;
    } arith_t;

endpackage

// File: rtl/aluflag_carry.sv
module aluflag_carry #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_half,
    output logic         c_top_in,
    output logic         c_out
);
    localparam int NIB = W / 2;

    logic [W:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]      = a[i] ^ b[i] ^ chain[i];
        assign chain[i+1]  = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
    end

    assign c_half   = chain[NIB];
    assign c_top_in = chain[W-1];
    assign c_out    = chain[W];
endmodule

// File: rtl/aluflag_arith.sv
module aluflag_arith
    import aluflag_pkg::*;
#(
    parameter int W = 8
) (
    input  opk_e         kind,
    input  logic         rot_dir,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] res_in,
    input  arith_t       cur,
    output arith_t       nxt
);
    logic         is_sub;
    logic [W-1:0] b_eff;
    logic [W-1:0] sum;
    logic         c_half;
    logic         c_top_in;
    logic         c_out;
    logic         rot_bit;

    assign is_sub = (kind == OPK_SUB);
    assign b_eff  = is_sub ? ~b : b;

    aluflag_carry #(.W(W)) u_chain (
        .a        (a),
        .b        (b_eff),
        .cin      (is_sub),
        .sum      (sum),
        .c_half   (c_half),
        .c_top_in (c_top_in),
        .c_out    (c_out)
    );

    assign rot_bit = rot_dir ? a[0] : a[W-1];

    always_comb begin
        nxt = cur;
        unique case (kind)
            OPK_ADD, OPK_SUB: begin
                nxt.cy  = c_out;
                nxt.hcy = c_half;
                nxt.zro = (sum == '0);
                nxt.ovf = c_top_in ^ c_out;
            end
            OPK_LOGIC: begin
                nxt.zro = (res_in == '0);
            end
            OPK_ROT: begin
                nxt.cy = rot_bit;
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/aluflag_pwr.sv
module aluflag_pwr (
    input  logic ev_pwrup,
    input  logic ev_halt,
    input  logic ev_wdt_clr,
    input  logic ev_wdt_to,
    input  logic pdn_q,
    input  logic tmo_q,
    output logic pdn_d,
    output logic tmo_d
);
    logic pdn_clr;
    logic tmo_clr;

    assign pdn_clr = ev_pwrup | ev_wdt_clr;
    assign tmo_clr = ev_pwrup | ev_wdt_clr | ev_halt;

    always_comb begin
        pdn_d = pdn_q;
        if (pdn_clr)      pdn_d = 1'b0;
        else if (ev_halt) pdn_d = 1'b1;

        tmo_d = tmo_q;
        if (tmo_clr)        tmo_d = 1'b0;
        else if (ev_wdt_to) tmo_d = 1'b1;
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import aluflag_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [1:0]   op_kind,
    input  logic         rot_dir,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [W-1:0] res_in,
    input  logic         sw_wr,
    input  logic [7:0]   sw_data,
    input  logic         ev_pwrup,
    input  logic         ev_halt,
    input  logic         ev_wdt_clr,
    input  logic         ev_wdt_to,
    output logic [7:0]   status_o
);
    status_t st_d, st_q;
    arith_t  ar_cur, ar_nxt;
    opk_e    kind;
    logic    pdn_d, tmo_d;

    assign kind   = opk_e'(op_kind);
    assign ar_cur = '{ovf: st_q.ovf, zro: st_q.zro, hcy: st_q.hcy, cy: st_q.cy};

    aluflag_arith #(.W(W)) u_arith (
        .kind    (kind),
        .rot_dir (rot_dir),
        .a       (opnd_a),
        .b       (opnd_b),
        .res_in  (res_in),
        .cur     (ar_cur),
        .nxt     (ar_nxt)
    );

    aluflag_pwr u_pwr (
        .ev_pwrup   (ev_pwrup),
        .ev_halt    (ev_halt),
        .ev_wdt_clr (ev_wdt_clr),
        .ev_wdt_to  (ev_wdt_to),
        .pdn_q      (st_q.pdn),
        .tmo_q      (st_q.tmo),
        .pdn_d      (pdn_d),
        .tmo_d      (tmo_d)
    );

    always_comb begin
        st_d     = st_q;
        st_d.pad = '0;
        if (sw_wr) begin
            st_d.cy  = sw_data[0];
            st_d.hcy = sw_data[1];
            st_d.zro = sw_data[2];
            st_d.ovf = sw_data[3];
        end else if (op_valid) begin
            st_d.cy  = ar_nxt.cy;
            st_d.hcy = ar_nxt.hcy;
            st_d.zro = ar_nxt.zro;
            st_d.ovf = ar_nxt.ovf;
        end
        st_d.pdn = pdn_d;
        st_d.tmo = tmo_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q;

    // independent reference arithmetic for the assertions
    logic [W:0] chk_add;
    logic       chk_ge;
    assign chk_add = {1'b0, opnd_a} + {1'b0, opnd_b};
    assign chk_ge  = (opnd_a >= opnd_b);

    a_r1_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7:6] == 2'b00);

    a_r2_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sw_wr && op_kind == 2'd0) |=> status_o[0] == $past(chk_add[W]));

    a_r3_sub_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sw_wr && op_kind == 2'd1) |=> status_o[0] == $past(chk_ge));

    a_r6_logic_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sw_wr && op_kind == 2'd2) |=>
            ($stable(status_o[0]) && $stable(status_o[1]) && $stable(status_o[3])));

    a_r7_rot_only_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sw_wr && op_kind == 2'd3) |=> $stable(status_o[3:1]));

    a_r8_halt_sets_pd: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_halt && !ev_pwrup && !ev_wdt_clr) |=> status_o[4]);

    a_r9_to_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pwrup || ev_wdt_clr || ev_halt) |=> !status_o[5]);

    a_r10_sw_no_power: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !ev_pwrup && !ev_halt && !ev_wdt_clr && !ev_wdt_to) |=> $stable(status_o[5:4]));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !sw_wr) |=> $stable(status_o[3:0]));
endmodule

// File: tb/sim_alu_flag_reg.sv
module sim_alu_flag_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [1:0] op_kind = 2'd0;
    logic       rot_dir = 1'b0;
    logic [7:0] opnd_a = '0, opnd_b = '0, res_in = '0;
    logic       sw_wr = 1'b0;
    logic [7:0] sw_data = '0;
    logic       ev_pwrup = 1'b0, ev_halt = 1'b0, ev_wdt_clr = 1'b0, ev_wdt_to = 1'b0;
    logic [7:0] status_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // model state
    logic m_c = 0, m_ac = 0, m_z = 0, m_ov = 0, m_pd = 0, m_to = 0;

    always #4 clk = ~clk;

    alu_flag_reg u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .rot_dir(rot_dir), .opnd_a(opnd_a), .opnd_b(opnd_b), .res_in(res_in),
        .sw_wr(sw_wr), .sw_data(sw_data), .ev_pwrup(ev_pwrup), .ev_halt(ev_halt),
        .ev_wdt_clr(ev_wdt_clr), .ev_wdt_to(ev_wdt_to), .status_o(status_o)
    );

    // {kind[1:0], dir, a[7:0], b[7:0], res[7:0]}
    localparam int NV = 18;
    localparam logic [26:0] VEC [NV] = '{
        {2'd0, 1'b0, 8'h0F, 8'h01, 8'h00},
        {2'd0, 1'b0, 8'hFF, 8'h01, 8'h00},
        {2'd2, 1'b0, 8'h00, 8'h00, 8'h5A},
        {2'd0, 1'b0, 8'h7F, 8'h01, 8'h00},
        {2'd2, 1'b0, 8'h00, 8'h00, 8'h00},
        {2'd0, 1'b0, 8'h80, 8'h80, 8'h00},
        {2'd0, 1'b0, 8'h12, 8'h34, 8'h00},
        {2'd1, 1'b0, 8'h05, 8'h05, 8'h00},
        {2'd1, 1'b0, 8'h03, 8'h05, 8'h00},
        {2'd1, 1'b0, 8'h10, 8'h01, 8'h00},
        {2'd1, 1'b0, 8'h80, 8'h01, 8'h00},
        {2'd1, 1'b0, 8'h7F, 8'hFF, 8'h00},
        {2'd3, 1'b0, 8'h80, 8'h00, 8'h00},
        {2'd3, 1'b1, 8'h02, 8'h00, 8'h00},
        {2'd3, 1'b1, 8'h01, 8'h00, 8'h00},
        {2'd3, 1'b0, 8'h7F, 8'h00, 8'h00},
        {2'd0, 1'b0, 8'h88, 8'h88, 8'h00},
        {2'd2, 1'b0, 8'h00, 8'h00, 8'h01}
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] mstat();
        return {2'b00, m_to, m_pd, m_ov, m_z, m_ac, m_c};
    endfunction

    task automatic clear_in();
        op_valid = 0; sw_wr = 0; ev_pwrup = 0; ev_halt = 0; ev_wdt_clr = 0; ev_wdt_to = 0;
    endtask

    task automatic model_op(input logic [1:0] k, input logic d, input logic [7:0] a,
                            input logic [7:0] b, input logic [7:0] r);
        int s;
        logic [7:0] rs;
        case (k)
            2'd0: begin
                s = int'(a) + int'(b); rs = s[7:0];
                m_c = (s > 255); m_ac = ((a & 8'h0F) + (b & 8'h0F)) > 15;
                m_z = (rs == 0); m_ov = (a[7] == b[7]) && (rs[7] != a[7]);
            end
            2'd1: begin
                rs = a - b;
                m_c = (a >= b); m_ac = (a[3:0] >= b[3:0]);
                m_z = (rs == 0); m_ov = (a[7] != b[7]) && (rs[7] != a[7]);
            end
            2'd2: m_z = (r == 0);
            default: m_c = d ? a[0] : a[7];
        endcase
    endtask

    task automatic do_op(input logic [1:0] k, input logic d, input logic [7:0] a,
                         input logic [7:0] b, input logic [7:0] r);
        @(negedge clk);
        op_valid = 1; op_kind = k; rot_dir = d; opnd_a = a; opnd_b = b; res_in = r;
        model_op(k, d, a, b, r);
        @(negedge clk);
        clear_in();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 reset value", status_o, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] k;
            logic [7:0] prev;
            prev = status_o;
            k = VEC[i][26:25];
            do_op(k, VEC[i][24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
            case (k)
                2'd0: begin
                    chk("R2 add carry/half-carry", status_o & 8'h03, mstat() & 8'h03);
                    chk("R4 add zero", status_o & 8'h04, mstat() & 8'h04);
                    chk("R5 add overflow", status_o & 8'h08, mstat() & 8'h08);
                end
                2'd1: begin
                    chk("R3 sub carry/half-carry", status_o & 8'h03, mstat() & 8'h03);
                    chk("R4 sub zero", status_o & 8'h04, mstat() & 8'h04);
                    chk("R5 sub overflow", status_o & 8'h08, mstat() & 8'h08);
                end
                2'd2: begin
                    chk("R4 logic zero", status_o & 8'h04, mstat() & 8'h04);
                    chk("R6 logic keeps C/AC/OV", status_o & 8'h0B, prev & 8'h0B);
                end
                default: begin
                    chk("R7 rotate carry", status_o & 8'h01, mstat() & 8'h01);
                    chk("R7 rotate keeps others", status_o & 8'h0E, prev & 8'h0E);
                end
            endcase
        end

        // R11 idle hold
        repeat (3) @(negedge clk);
        chk("R11 idle hold", status_o, mstat());

        // R8 halt sets power-down
        ev_halt = 1; m_pd = 1; m_to = 0;
        @(negedge clk); clear_in();
        chk("R8 halt sets pd", status_o, mstat());
        // R9 time-out set
        ev_wdt_to = 1; m_to = 1;
        @(negedge clk); clear_in();
        chk("R9 wdt timeout sets to", status_o, mstat());
        // R9 halt clears to even with simultaneous timeout
        ev_halt = 1; ev_wdt_to = 1; m_to = 0; m_pd = 1;
        @(negedge clk); clear_in();
        chk("R9 halt beats timeout", status_o, mstat());
        // R8 clear beats halt
        ev_wdt_clr = 1; ev_halt = 1; m_pd = 0; m_to = 0;
        @(negedge clk); clear_in();
        chk("R8 wdt clear beats halt", status_o, mstat());
        // R8/R9 power-up clears both
        ev_halt = 1; @(negedge clk); clear_in();
        ev_wdt_to = 1; @(negedge clk); clear_in();
        m_pd = 1; m_to = 1;
        chk("R9 both set before powerup", status_o, mstat());
        ev_pwrup = 1; ev_halt = 1; ev_wdt_to = 1; m_pd = 0; m_to = 0;
        @(negedge clk); clear_in();
        chk("R8 powerup clears pd and to", status_o, mstat());

        // R10 software write: upper data ignored, power flags kept
        ev_halt = 1; @(negedge clk); clear_in(); m_pd = 1;
        sw_wr = 1; sw_data = 8'hEA; m_c = 0; m_ac = 1; m_z = 0; m_ov = 1;
        @(negedge clk); clear_in();
        chk("R10 sw write low bits, upper ignored", status_o, mstat());
        sw_wr = 1; sw_data = 8'hFF; m_c = 1; m_ac = 1; m_z = 1; m_ov = 1;
        @(negedge clk); clear_in();
        chk("R1 top bits zero after 0xFF write", status_o & 8'hC0, 8'h00);
        chk("R10 sw write 0xFF", status_o, mstat());
        // R10 sw beats op in same cycle
        sw_wr = 1; sw_data = 8'h05; op_valid = 1; op_kind = 2'd0; opnd_a = 8'h01; opnd_b = 8'h01;
        m_c = 1; m_ac = 0; m_z = 1; m_ov = 0;
        @(negedge clk); clear_in();
        chk("R10 sw wins over op", status_o, mstat());

        // R12 single-edge latency: not visible before the edge
        @(negedge clk);
        op_valid = 1; op_kind = 2'd0; opnd_a = 8'hFF; opnd_b = 8'h02;
        #1 chk("R12 no change before edge", status_o, mstat());
        model_op(2'd0, 1'b0, 8'hFF, 8'h02, 8'h00);
        @(negedge clk); clear_in();
        chk("R12 change after one edge", status_o, mstat());

        // R1 reset again clears all
        rst_n = 0; @(negedge clk); rst_n = 1;
        chk("R1 reset clears", status_o, 8'h00);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule